// File: doc/BRIEF.md
# Multi-Source Domain Reset Generator

This block turns a handful of raw, active-low reset sources into ten separate active-low domain resets. Three sources are power-class events: power-on, brown-out and an external enable pin. A fourth is an always-on watchdog, and the last is an active-high system-reset request from the CPU. The first three are ANDed into one power-management reset. That reset is ANDed with the watchdog reset to form the power reset. A power reset clears every domain. A CPU request clears only the system group of domains. It leaves the power state controller, the always-on power control and the debug logic running, so that a debugger attached across a software reset keeps its session.

Each domain reset goes low asynchronously. It is released synchronously through a two-flop synchronizer and then held for a further sixteen clock cycles. The power group is released first and serves as the core reset. The system group is the core reset combined with a captured copy of the CPU request, so a request that is one cycle wide still produces a full reset. A sticky four-bit cause register records why the last reset happened. Software reads it on a plain output and clears bits with a write-one-to-clear strobe and mask.

The clock is assumed to run during reset.

Top module: `rstgen_top`

## Requirements
- R1: If any of `por_n_i`, `bor_n_i`, `pin_n_i` or `wdt_n_i` is low, all ten bits of `dom_rst_n_o` are low without waiting for a clock edge.
- R2: The power group is bits 0 (power state controller), 1 (always-on power control) and 9 (debug). After the last power source goes high between two edges, it stays low through the 18th following rising edge and goes high on the 19th.
- R3: The system group is bits 2 (always-on peripherals), 3 (always-on memory control), 4 (other always-on logic), 5 (radio timer), 6 (radio core), 7 (MCU subsystem) and 8 (CPU core). It goes high on the 38th rising edge after the power sources release, which is 19 edges after the power group, and never while the power group is low.
- R4: A high `sys_req_i` at a rising edge while the power group is released drives the system group low right after that edge. The power group stays high throughout.
- R5: A request captured last at edge k releases the system group on edge k+20. This holds both for a single-cycle pulse and for a request held over several edges.
- R6: While the power group is low, `sys_req_i` has no effect. It neither delays the system release from edge 38 nor sets a cause bit.
- R7: `cause_o` bit 0 means power-on or brown-out, bit 1 means external pin, bit 2 means watchdog and bit 3 means software request. While `por_n_i` or `bor_n_i` is low, `cause_o` is 4'b0001.
- R8: A falling external pin or watchdog source replaces `cause_o` with only its own bit or bits (1 and/or 2) by the third rising edge, discarding older bits.
- R9: A software request that takes effect (R4) sets bit 3 and keeps the other bits. The bits survive the software reset.
- R10: A high `cause_clr_i` at a rising edge clears each `cause_o` bit whose `cause_clr_mask_i` bit is 1 and leaves the rest unchanged. A zero mask changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for release and cause logic |
| por_n_i | input | 1 | Power-on reset, active low |
| bor_n_i | input | 1 | Brown-out reset, active low |
| pin_n_i | input | 1 | External enable pin reset, active low |
| wdt_n_i | input | 1 | Always-on watchdog reset, active low |
| sys_req_i | input | 1 | CPU system-reset request, active high |
| cause_clr_i | input | 1 | Write-one-to-clear strobe for the cause register |
| cause_clr_mask_i | input | 4 | Cause bits to clear when the strobe is high |
| dom_rst_n_o | output | 10 | Per-domain active-low resets, bit map in R2/R3 |
| cause_o | output | 4 | Sticky reset-cause record, encoding in R7 |

## Verification
The bench measures release edges exactly. A synchronizer or counter that is off by one moves the power release away from edge 19, or the system release away from edge 38 or k+20, and the bench catches either shift. A single-cycle CPU pulse and a held request are both applied. A design that did not capture the pulse would release early or never reset, and one that cleared the capture too soon would cut a held request short. The bench also issues a request during power reset, where a design that did not gate it would stretch the system release or log a false software cause. Cause tests cover replacement by the pin and by the watchdog, survival of bit 3 through the software reset, and masked clears. A wrong priority or a missing mask would leave stale or missing bits.

// File: rtl/rstgen_pkg.sv
// Shared constants for the domain reset generator: domain bit map,
// group membership and reset-cause bit positions.
package rstgen_pkg;
    localparam int NUM_DOM        = 10;
    localparam int DOM_PSC        = 0;
    localparam int DOM_AON_PWR    = 1;
    localparam int DOM_AON_PERIPH = 2;
    localparam int DOM_AON_MEM    = 3;
    localparam int DOM_AON_MISC   = 4;
    localparam int DOM_RADIO_TMR  = 5;
    localparam int DOM_RADIO_CORE = 6;
    localparam int DOM_MCU        = 7;
    localparam int DOM_CPU        = 8;
    localparam int DOM_DBG        = 9;

    // Domains that a CPU request spares (reset only by power-class sources).
    localparam logic [NUM_DOM-1:0] PWR_GROUP = 10'b10_0000_0011;

    localparam int CAUSE_W   = 4;
    localparam int CAUSE_PWR = 0;
    localparam int CAUSE_PIN = 1;
    localparam int CAUSE_WDT = 2;
    localparam int CAUSE_SW  = 3;

    localparam logic [CAUSE_W-1:0] CAUSE_AT_POR = 4'b0001;
endpackage

// File: rtl/rstgen_stretch.sv
// Reset release stretcher.
// Drives rst_n_o low as soon as src_n_i falls (asynchronous assertion).
// After src_n_i rises, the release is first synchronized through
// SYNC_STAGES flops and then held for HOLD_CYCLES more cycles; rst_n_o
// rises on edge SYNC_STAGES + HOLD_CYCLES + 1. Assumes SYNC_STAGES >= 2
// and that src_n_i is glitch-free.
module rstgen_stretch #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic src_n_i,
    output logic rst_n_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   out_q;

    // Synchronize release, count hold cycles, then let the output go high.
    always_ff @(posedge clk or negedge src_n_i) begin
        if (!src_n_i) begin
            sync_q <= '0;
            cnt_q  <= '0;
            out_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
            if (sync_q[SYNC_STAGES-1] && (cnt_q != HOLD_LAST)) begin
                cnt_q <= cnt_q + 1'b1;
            end
            out_q <= (cnt_q == HOLD_LAST);
        end
    end

    assign rst_n_o = out_q;
endmodule

// File: rtl/rstgen_cause.sv
// Sticky reset-cause register.
// Loaded with the power-on/brown-out code while porbod_n_i is low.
// Falling edges of the pin and watchdog sources, seen through
// synchronizers, replace the contents with their own bits. A CPU request
// taken while the core reset is released sets the software bit. Software
// clears bits with a strobe and mask. Assumes clk runs during reset.
module rstgen_cause
    import rstgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               porbod_n_i,
    input  logic               pin_n_i,
    input  logic               wdt_n_i,
    input  logic               core_rst_n_i,
    input  logic               sys_req_i,
    input  logic               clr_i,
    input  logic [CAUSE_W-1:0] clr_mask_i,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int NUM_EV = 2;

    logic [NUM_EV-1:0]  raw_n;
    logic [NUM_EV-1:0]  ev;
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] cause_nxt;
    logic               sw_hit;

    assign raw_n = {wdt_n_i, pin_n_i};

    for (genvar s = 0; s < NUM_EV; s++) begin : g_src
        logic [SYNC_STAGES:0] chain_q;
        // Synchronize the raw source and keep one extra stage for edge detect.
        always_ff @(posedge clk or negedge porbod_n_i) begin
            if (!porbod_n_i) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[SYNC_STAGES-1:0], raw_n[s]};
            end
        end
        assign ev[s] = chain_q[SYNC_STAGES] & ~chain_q[SYNC_STAGES-1];
    end

    assign sw_hit = sys_req_i & core_rst_n_i;

    // Next cause: clear by mask, set software bit, hardware events replace.
    always_comb begin
        cause_nxt = cause_q;
        if (clr_i) begin
            cause_nxt = cause_nxt & ~clr_mask_i;
        end
        if (sw_hit) begin
            cause_nxt[CAUSE_SW] = 1'b1;
        end
        if (|ev) begin
            cause_nxt            = '0;
            cause_nxt[CAUSE_PIN] = ev[0];
            cause_nxt[CAUSE_WDT] = ev[1];
        end
    end

    // Hold the cause record; power-on/brown-out forces its own code.
    always_ff @(posedge clk or negedge porbod_n_i) begin
        if (!porbod_n_i) begin
            cause_q <= CAUSE_AT_POR;
        end else begin
            cause_q <= cause_nxt;
        end
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/rstgen_top.sv
// Multi-source domain reset generator.
// Combines power-class sources and the watchdog into the power reset,
// stretches it into the power-group resets (which double as the core
// reset), and derives the system-group resets from the core reset and a
// captured CPU request. Every output asserts asynchronously and releases
// through a synchronizer plus hold counter. Assumes clk runs during reset.
module rstgen_top
    import rstgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 16
) (
    input  logic               clk,
    input  logic               por_n_i,
    input  logic               bor_n_i,
    input  logic               pin_n_i,
    input  logic               wdt_n_i,
    input  logic               sys_req_i,
    input  logic               cause_clr_i,
    input  logic [CAUSE_W-1:0] cause_clr_mask_i,
    output logic [NUM_DOM-1:0] dom_rst_n_o,
    output logic [CAUSE_W-1:0] cause_o
);
    logic porbod_n;
    logic pmu_rst_n;
    logic pwr_src_n;
    logic core_rst_n;
    logic sys_src_n;
    logic sys_rst_n;
    logic req_pend_q;

    assign porbod_n  = por_n_i & bor_n_i;
    assign pmu_rst_n = porbod_n & pin_n_i;
    assign pwr_src_n = pmu_rst_n & wdt_n_i;

    rstgen_stretch #(
        .SYNC_STAGES (SYNC_STAGES),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_pwr_str (
        .clk     (clk),
        .src_n_i (pwr_src_n),
        .rst_n_o (core_rst_n)
    );

    // Capture the CPU request and hold it until the system reset is applied.
    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            req_pend_q <= 1'b0;
        end else begin
            req_pend_q <= sys_req_i | (req_pend_q & sys_rst_n);
        end
    end

    assign sys_src_n = core_rst_n & ~req_pend_q;

    rstgen_stretch #(
        .SYNC_STAGES (SYNC_STAGES),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_sys_str (
        .clk     (clk),
        .src_n_i (sys_src_n),
        .rst_n_o (sys_rst_n)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        if (PWR_GROUP[d]) begin : g_pwr
            assign dom_rst_n_o[d] = core_rst_n;
        end else begin : g_sys
            assign dom_rst_n_o[d] = sys_rst_n;
        end
    end

    rstgen_cause #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cause (
        .clk          (clk),
        .porbod_n_i   (porbod_n),
        .pin_n_i      (pin_n_i),
        .wdt_n_i      (wdt_n_i),
        .core_rst_n_i (core_rst_n),
        .sys_req_i    (sys_req_i),
        .clr_i        (cause_clr_i),
        .clr_mask_i   (cause_clr_mask_i),
        .cause_o      (cause_o)
    );
endmodule

// File: rtl/rstgen_top_chk.sv
// Port-level property checker for rstgen_top, attached with bind.
// Assumes the power-on input is low at the first clock edge.
module rstgen_top_chk
    import rstgen_pkg::*;
(
    input logic               clk,
    input logic               por_n_i,
    input logic               bor_n_i,
    input logic               pin_n_i,
    input logic               wdt_n_i,
    input logic               sys_req_i,
    input logic               cause_clr_i,
    input logic [CAUSE_W-1:0] cause_clr_mask_i,
    input logic [NUM_DOM-1:0] dom_rst_n_o,
    input logic [CAUSE_W-1:0] cause_o
);
    logic srcs_ok;
    assign srcs_ok = por_n_i & bor_n_i & pin_n_i & wdt_n_i;

    assert_all_low_R1: assert property (@(posedge clk) disable iff (!por_n_i)
        (!bor_n_i || !pin_n_i || !wdt_n_i) |-> (dom_rst_n_o == '0));

    assert_sys_after_pwr_R3: assert property (@(posedge clk) disable iff (!por_n_i)
        !dom_rst_n_o[DOM_PSC] |-> ((dom_rst_n_o & ~PWR_GROUP) == '0));

    assert_req_resets_sys_R4: assert property (@(posedge clk) disable iff (!por_n_i)
        (sys_req_i && dom_rst_n_o[DOM_PSC]) |=> !dom_rst_n_o[DOM_MCU]);

    assert_pwr_spared_R4: assert property (@(posedge clk) disable iff (!por_n_i)
        (srcs_ok && $past(srcs_ok) && $past(dom_rst_n_o[DOM_PSC])) |-> dom_rst_n_o[DOM_PSC]);

    assert_sw_bit_sticky_R9: assert property (@(posedge clk) disable iff (!por_n_i)
        $fell(cause_o[CAUSE_SW]) |->
            ($past(cause_clr_i && cause_clr_mask_i[CAUSE_SW]) || (cause_o[CAUSE_WDT:CAUSE_PIN] != '0)));

    assert_mask_clear_R10: assert property (@(posedge clk) disable iff (!por_n_i)
        (cause_clr_i && cause_clr_mask_i[CAUSE_PWR] && bor_n_i) |=> !cause_o[CAUSE_PWR]);
endmodule

bind rstgen_top rstgen_top_chk u_chk (
    .clk              (clk),
    .por_n_i          (por_n_i),
    .bor_n_i          (bor_n_i),
    .pin_n_i          (pin_n_i),
    .wdt_n_i          (wdt_n_i),
    .sys_req_i        (sys_req_i),
    .cause_clr_i      (cause_clr_i),
    .cause_clr_mask_i (cause_clr_mask_i),
    .dom_rst_n_o      (dom_rst_n_o),
    .cause_o          (cause_o)
);

// File: tb/rstgen_top_tb.sv
// Self-checking bench for rstgen_top: a source-pattern table walked by a
// loop, then directed timing, request, gating and cause-clear tests.
module rstgen_top_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       bor_n = 1'b1;
    logic       pin_n = 1'b1;
    logic       wdt_n = 1'b1;
    logic       sys_req = 1'b0;
    logic       clr = 1'b0;
    logic [3:0] clr_mask = 4'b0000;
    logic [9:0] dom_n;
    logic [3:0] cause;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    localparam logic [9:0] PWR_BITS = 10'b10_0000_0011;
    localparam logic [9:0] ALL_ON   = 10'b11_1111_1111;

    // {por_n, bor_n, pin_n, wdt_n} applied, expected cause after release
    localparam logic [7:0] VEC_TBL [0:5] = '{
        8'b0111_0001,
        8'b1011_0001,
        8'b1101_0010,
        8'b1110_0100,
        8'b1100_0110,
        8'b1001_0001
    };

    always #2 clk = ~clk;

    rstgen_top u_dut (
        .clk              (clk),
        .por_n_i          (por_n),
        .bor_n_i          (bor_n),
        .pin_n_i          (pin_n),
        .wdt_n_i          (wdt_n),
        .sys_req_i        (sys_req),
        .cause_clr_i      (clr),
        .cause_clr_mask_i (clr_mask),
        .dom_rst_n_o      (dom_n),
        .cause_o          (cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sw_pulse();
        @(negedge clk) sys_req = 1'b1;
        @(negedge clk) sys_req = 1'b0;
        #1;
    endtask

    task automatic clear_cause(input logic [3:0] m);
        @(negedge clk) begin clr = 1'b1; clr_mask = m; end
        @(negedge clk) begin clr = 1'b0; clr_mask = 4'b0000; end
        #1;
    endtask

    initial begin
        // Reset state while power-on is held low (R1, R7)
        wait_edges(4);
        chk("R1 reset dom", 32'(dom_n), 32'h0);
        chk("R7 reset cause", 32'(cause), 32'h1);

        // Exact release edges (R2, R3)
        @(negedge clk) por_n = 1'b1;
        wait_edges(18);
        chk("R2 pwr low at edge 18", 32'(dom_n), 32'h0);
        wait_edges(1);
        chk("R2 pwr high at edge 19", 32'(dom_n), 32'(PWR_BITS));
        wait_edges(18);
        chk("R3 sys low at edge 37", 32'(dom_n), 32'(PWR_BITS));
        wait_edges(1);
        chk("R3 sys high at edge 38", 32'(dom_n), 32'(ALL_ON));

        // Table of source patterns (R1, R7, R8)
        for (int i = 0; i < 6; i++) begin
            @(negedge clk) {por_n, bor_n, pin_n, wdt_n} = VEC_TBL[i][7:4];
            #1;
            chk("R1 async assert", 32'(dom_n), 32'h0);
            wait_edges(6);
            @(negedge clk) {por_n, bor_n, pin_n, wdt_n} = 4'b1111;
            wait_edges(45);
            chk("R3 released after table row", 32'(dom_n), 32'(ALL_ON));
            chk("R8 cause after table row", 32'(cause), 32'(VEC_TBL[i][3:0]));
        end

        // Single-cycle software request (R4, R5, R9)
        sw_pulse();
        chk("R4 sys low, pwr spared", 32'(dom_n), 32'(PWR_BITS));
        chk("R9 sw bit added", 32'(cause), 32'h9);
        wait_edges(19);
        chk("R5 pulse still held at k+19", 32'(dom_n), 32'(PWR_BITS));
        wait_edges(1);
        chk("R5 pulse released at k+20", 32'(dom_n), 32'(ALL_ON));

        // Request held over five edges (R5)
        @(negedge clk) sys_req = 1'b1;
        repeat (5) @(negedge clk);
        sys_req = 1'b0;
        #1;
        chk("R5 held request asserts", 32'(dom_n), 32'(PWR_BITS));
        wait_edges(19);
        chk("R5 held still low at k+23", 32'(dom_n), 32'(PWR_BITS));
        wait_edges(1);
        chk("R5 held released at k+24", 32'(dom_n), 32'(ALL_ON));
        chk("R9 survives sw reset", 32'(cause), 32'h9);

        // Pin event replaces older bits (R8)
        @(negedge clk) pin_n = 1'b0;
        wait_edges(6);
        @(negedge clk) pin_n = 1'b1;
        wait_edges(45);
        chk("R8 pin replaces cause", 32'(cause), 32'h2);

        // Software bit on top of pin bit, then masked clears (R9, R10)
        sw_pulse();
        wait_edges(25);
        chk("R9 sw bit kept with pin bit", 32'(cause), 32'hA);
        clear_cause(4'b0010);
        chk("R10 clear pin bit only", 32'(cause), 32'h8);
        clear_cause(4'b0000);
        chk("R10 zero mask no change", 32'(cause), 32'h8);
        clear_cause(4'b1000);
        chk("R10 clear sw bit", 32'(cause), 32'h0);

        // Watchdog event (R8)
        @(negedge clk) wdt_n = 1'b0;
        wait_edges(3);
        chk("R8 wdt cause by edge 3", 32'(cause), 32'h4);
        @(negedge clk) wdt_n = 1'b1;
        wait_edges(45);

        // Request during power reset is ignored (R6)
        @(negedge clk) por_n = 1'b0;
        wait_edges(3);
        @(negedge clk) por_n = 1'b1;
        wait_edges(5);
        sw_pulse();
        wait_edges(31);
        chk("R6 sys still low at edge 37", 32'(dom_n), 32'(PWR_BITS));
        wait_edges(1);
        chk("R6 sys released at edge 38", 32'(dom_n), 32'(ALL_ON));
        chk("R6 no sw cause", 32'(cause), 32'h1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule